// File: doc/BRIEF.md
# Serial Port Interrupt Request Logic

This block keeps the six status flags of a UART-style serial port and turns them into four interrupt request lines: transmit buffer empty, transmission finished, receive buffer full and receive error. The serial shifter pulses a per-flag set input when an event occurs. Software clears a flag by first reading the status and then writing a clear. A DMA controller, or a second transfer engine, can clear the transmit-empty or receive-full flag in hardware when it services the matching request.

Each request line is gated by its own enable input. A registered vector output names the most urgent pending enabled source, with a valid bit. All outputs are registered. At a clock edge the flags, request lines and vector all take the values that follow from the inputs sampled at that edge. Reset is synchronous and active high.

Status bit positions are fixed and are used by all requirements: bit 0 transmit-empty, bit 1 transmit-end, bit 2 receive-full, bit 3 overrun, bit 4 parity error, bit 5 framing error.

Top module: `sci_irq_ctrl`

## Requirements
- R1: After reset, `status` is 6'b000011 (transmit-empty and transmit-end set, all other flags clear), all four request lines are 0 and `vec_valid` is 0.
- R2: A 1 on `flag_set[i]` makes `status[i]` equal to 1 in the cycle after the edge that samples it.
- R3: A 1 on `cpu_rd` arms every flag that is 1 at that edge. A later `cpu_clr[i]` clears `status[i]` only if flag i is armed. A clear attempt uses up the arming, and a clear on an unarmed flag has no effect.
- R4: If `flag_set[i]` and an effective clear of flag i (by software or hardware) fall in the same cycle, the flag stays 1.
- R5: `irq_txe` equals status bit 0 AND `en_txe`, and `irq_rxf` equals status bit 2 AND `en_rxf`. Both are taken from the flag values and enables at the same edge.
- R6: `irq_tend` is 1 only when status bit 1 and `en_tend` are both 1.
- R7: `irq_err` equals (status bit 3 OR bit 4 OR bit 5) AND `en_err`.
- R8: `dma_tx_ack` clears status bit 0, and `dma_rx_ack` clears status bit 2. No prior read is needed.
- R9: `xfer_tx_ack` clears status bit 0, and `xfer_rx_ack` clears status bit 2, only when `xfer_hold` is 0 and `xfer_cnt_zero` is 0. In every other case the ack has no effect.
- R10: `vec` encodes the highest-priority active request. The codes are 0 for error, 1 for receive-full, 2 for transmit-empty and 3 for transmit-end, and that is also the priority order. Transmit-empty wins over a simultaneous transmit-end. With no request active, `vec_valid` is 0 and `vec` is 0.
- R11: If transmit-empty and transmit-end are cleared in the same cycle, no transmit-end request appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_set | input | 6 | Per-flag set pulses from the shifter |
| cpu_rd | input | 1 | Software status read strobe (arms flags that are 1) |
| cpu_clr | input | 6 | Software per-flag clear-write strobes |
| en_txe | input | 1 | Transmit-empty request enable |
| en_tend | input | 1 | Transmit-end request enable |
| en_rxf | input | 1 | Receive-full request enable |
| en_err | input | 1 | Receive-error request enable |
| dma_tx_ack | input | 1 | DMA serviced transmit-empty |
| dma_rx_ack | input | 1 | DMA serviced receive-full |
| xfer_tx_ack | input | 1 | Second engine serviced transmit-empty |
| xfer_rx_ack | input | 1 | Second engine serviced receive-full |
| xfer_hold | input | 1 | Second engine disable-on-completion setting |
| xfer_cnt_zero | input | 1 | Second engine transfer counter is zero |
| status | output | 6 | Registered flag values |
| irq_txe | output | 1 | Transmit-empty request |
| irq_tend | output | 1 | Transmit-end request |
| irq_rxf | output | 1 | Receive-full request |
| irq_err | output | 1 | Receive-error request |
| vec | output | 2 | Code of the winning request |
| vec_valid | output | 1 | Any request active |

## Verification
The bench targets several corner cases:
- A clear write with no prior read. A design that ignored arming would drop the flag.
- A set and a clear in the same cycle. A design with the wrong precedence would lose the event.
- The second engine acking while its hold bit is set or its counter is zero. A design that skipped these conditions would clear the flag wrongly.
- Both transmit flags cleared together. A wrong design would raise a stray transmit-end request or vector.
- Transmit-empty and transmit-end pending together. An inverted priority would report code 3 instead of 2.

Long random traffic then mixes all of these against a behavioural model.

// File: rtl/sci_irq_pkg.sv
package sci_irq_pkg;
  localparam int NFLAG = 6;
  localparam int NREQ  = 4;
  localparam int VW    = $clog2(NREQ);
  // flag positions
  localparam int F_TXE  = 0;
  localparam int F_TEND = 1;
  localparam int F_RXF  = 2;
  localparam int F_OVR  = 3;
  localparam int F_PER  = 4;
  localparam int F_FER  = 5;
  localparam logic [NFLAG-1:0] FLAG_RST = 6'b000011;
  // request index equals vector code; lower index has higher priority
  typedef enum logic [VW-1:0] {
    V_ERR  = 2'd0,
    V_RXF  = 2'd1,
    V_TXE  = 2'd2,
    V_TEND = 2'd3
  } vec_e;
endpackage

// File: rtl/sci_flag_cell.sv
module sci_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_i,
  input  logic hw_clr_i,
  output logic flag_o,
  output logic flag_d_o
);
  logic armed_q;
  logic armed_d;
  logic clr_ok;

  assign clr_ok   = (clr_i && armed_q) || hw_clr_i;
  assign flag_d_o = set_i || (flag_o && !clr_ok);
  assign armed_d  = flag_d_o && ((armed_q && !clr_i) || (rd_i && flag_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= RST_VAL;
      armed_q <= 1'b0;
    end else begin
      flag_o  <= flag_d_o;
      armed_q <= armed_d;
    end
  end

  // R2 / R4: a set event is never lost
  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R3: an unarmed clear leaves the flag alone
  a_r3_unarmed_clear_ignored: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !armed_q && !set_i && !hw_clr_i) |=> flag_o);
  // R8: hardware clear drops the flag
  a_r8_hw_clear: assert property (@(posedge clk) disable iff (rst)
    (hw_clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/sci_irq_prio.sv
module sci_irq_prio
  import sci_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req_d,
  output logic [NREQ-1:0] irq_q,
  output logic [VW-1:0]   vec_q,
  output logic            valid_q
);
  logic [VW-1:0] win;

  always_comb begin
    win = '0;
    for (int i = NREQ-1; i >= 0; i--) begin
      if (req_d[i]) win = VW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= '0;
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      irq_q   <= req_d;
      vec_q   <= win;
      valid_q <= |req_d;
    end
  end

  // R10: valid tracks pending requests, code names an active one
  a_r10_valid_matches: assert property (@(posedge clk) disable iff (rst)
    valid_q == (|irq_q));
  a_r10_code_active: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> irq_q[vec_q]);
  a_r10_txe_over_tend: assert property (@(posedge clk) disable iff (rst)
    (irq_q[V_TXE] && irq_q[V_TEND] && !irq_q[V_ERR] && !irq_q[V_RXF]) |-> vec_q == V_TXE);
endmodule

// File: rtl/sci_irq_ctrl.sv
module sci_irq_ctrl
  import sci_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flag_set,
  input  logic             cpu_rd,
  input  logic [NFLAG-1:0] cpu_clr,
  input  logic             en_txe,
  input  logic             en_tend,
  input  logic             en_rxf,
  input  logic             en_err,
  input  logic             dma_tx_ack,
  input  logic             dma_rx_ack,
  input  logic             xfer_tx_ack,
  input  logic             xfer_rx_ack,
  input  logic             xfer_hold,
  input  logic             xfer_cnt_zero,
  output logic [NFLAG-1:0] status,
  output logic             irq_txe,
  output logic             irq_tend,
  output logic             irq_rxf,
  output logic             irq_err,
  output logic [VW-1:0]    vec,
  output logic             vec_valid
);
  logic             xfer_ok;
  logic [NFLAG-1:0] hw_clr;
  logic [NFLAG-1:0] flag_d;
  logic [NREQ-1:0]  req_d;
  logic [NREQ-1:0]  irq_q;

  // R9: second engine clears only with hold off and counter non-zero
  assign xfer_ok = !xfer_hold && !xfer_cnt_zero;

  always_comb begin
    hw_clr        = '0;
    hw_clr[F_TXE] = dma_tx_ack || (xfer_tx_ack && xfer_ok);
    hw_clr[F_RXF] = dma_rx_ack || (xfer_rx_ack && xfer_ok);
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sci_flag_cell #(.RST_VAL(FLAG_RST[g])) u_cell (
      .clk      (clk),
      .rst      (rst),
      .set_i    (flag_set[g]),
      .rd_i     (cpu_rd),
      .clr_i    (cpu_clr[g]),
      .hw_clr_i (hw_clr[g]),
      .flag_o   (status[g]),
      .flag_d_o (flag_d[g])
    );
  end

  always_comb begin
    req_d         = '0;
    req_d[V_ERR]  = (flag_d[F_OVR] || flag_d[F_PER] || flag_d[F_FER]) && en_err;
    req_d[V_RXF]  = flag_d[F_RXF] && en_rxf;
    req_d[V_TXE]  = flag_d[F_TXE] && en_txe;
    req_d[V_TEND] = flag_d[F_TEND] && en_tend;
  end

  sci_irq_prio u_prio (
    .clk     (clk),
    .rst     (rst),
    .req_d   (req_d),
    .irq_q   (irq_q),
    .vec_q   (vec),
    .valid_q (vec_valid)
  );

  assign irq_err  = irq_q[V_ERR];
  assign irq_rxf  = irq_q[V_RXF];
  assign irq_txe  = irq_q[V_TXE];
  assign irq_tend = irq_q[V_TEND];

  // R6: transmit-end request needs its flag
  a_r6_tend_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_tend |-> status[F_TEND]);
  // R7: error request needs an error flag
  a_r7_err_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> (status[F_OVR] || status[F_PER] || status[F_FER]));
  // R9: a blocked second-engine ack does not clear transmit-empty
  a_r9_xfer_blocked: assert property (@(posedge clk) disable iff (rst)
    (status[F_TXE] && xfer_tx_ack && (xfer_hold || xfer_cnt_zero) && !dma_tx_ack && !cpu_clr[F_TXE])
      |=> status[F_TXE]);
  // R11: both transmit flags cleared together leaves no transmit-end request
  a_r11_no_late_tend: assert property (@(posedge clk) disable iff (rst)
    ($fell(status[F_TXE]) && $fell(status[F_TEND])) |-> !irq_tend);
endmodule

// File: tb/tb_sci_irq_ctrl.sv
module tb_sci_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] flag_set = '0;
  logic cpu_rd = 1'b0;
  logic [5:0] cpu_clr = '0;
  logic en_txe = 1'b0, en_tend = 1'b0, en_rxf = 1'b0, en_err = 1'b0;
  logic dma_tx_ack = 1'b0, dma_rx_ack = 1'b0;
  logic xfer_tx_ack = 1'b0, xfer_rx_ack = 1'b0;
  logic xfer_hold = 1'b0, xfer_cnt_zero = 1'b0;
  logic [5:0] status;
  logic irq_txe, irq_tend, irq_rxf, irq_err, vec_valid;
  logic [1:0] vec;

  always #2 clk = ~clk;

  sci_irq_ctrl dut (
    .clk(clk), .rst(rst), .flag_set(flag_set), .cpu_rd(cpu_rd), .cpu_clr(cpu_clr),
    .en_txe(en_txe), .en_tend(en_tend), .en_rxf(en_rxf), .en_err(en_err),
    .dma_tx_ack(dma_tx_ack), .dma_rx_ack(dma_rx_ack),
    .xfer_tx_ack(xfer_tx_ack), .xfer_rx_ack(xfer_rx_ack),
    .xfer_hold(xfer_hold), .xfer_cnt_zero(xfer_cnt_zero),
    .status(status), .irq_txe(irq_txe), .irq_tend(irq_tend), .irq_rxf(irq_rxf),
    .irq_err(irq_err), .vec(vec), .vec_valid(vec_valid)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit [5:0] m_flag, m_arm;
  bit m_txe, m_tend, m_rxf, m_err, m_valid, m_live;
  int m_vec;

  always @(posedge clk) begin
    bit [5:0] nf, na, hw;
    bit ok;
    if (rst) begin
      m_flag = 6'b000011; m_arm = 0;
      m_txe = 0; m_tend = 0; m_rxf = 0; m_err = 0; m_valid = 0; m_vec = 0;
    end else begin
      ok = !xfer_hold && !xfer_cnt_zero;
      hw = 0;
      hw[0] = dma_tx_ack || (xfer_tx_ack && ok);
      hw[2] = dma_rx_ack || (xfer_rx_ack && ok);
      for (int i = 0; i < 6; i++) begin
        if (flag_set[i]) nf[i] = 1;
        else if (hw[i] || (cpu_clr[i] && m_arm[i])) nf[i] = 0;
        else nf[i] = m_flag[i];
        na[i] = nf[i] && ((m_arm[i] && !cpu_clr[i]) || (cpu_rd && m_flag[i]));
      end
      m_flag = nf; m_arm = na;
      m_err  = (nf[3] || nf[4] || nf[5]) && en_err;
      m_rxf  = nf[2] && en_rxf;
      m_txe  = nf[0] && en_txe;
      m_tend = nf[1] && en_tend;
      m_valid = m_err || m_rxf || m_txe || m_tend;
      m_vec = m_err ? 0 : m_rxf ? 1 : m_txe ? 2 : m_tend ? 3 : 0;
    end
    m_live = 1;
  end

  always @(negedge clk) begin
    if (m_live && !done) begin
      chk("R2", "status", {2'b0, status}, {2'b0, m_flag});
      chk("R5", "irq_txe", {7'b0, irq_txe}, {7'b0, m_txe});
      chk("R5", "irq_rxf", {7'b0, irq_rxf}, {7'b0, m_rxf});
      chk("R6", "irq_tend", {7'b0, irq_tend}, {7'b0, m_tend});
      chk("R7", "irq_err", {7'b0, irq_err}, {7'b0, m_err});
      chk("R10", "vec_valid", {7'b0, vec_valid}, {7'b0, m_valid});
      chk("R10", "vec", {6'b0, vec}, 8'(m_vec));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    flag_set = '0; cpu_rd = 0; cpu_clr = '0;
    dma_tx_ack = 0; dma_rx_ack = 0; xfer_tx_ack = 0; xfer_rx_ack = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); tick();
    rst = 0;
    // R1 reset state
    chk("R1", "status", {2'b0, status}, 8'h03);
    chk("R1", "irqs", {4'b0, irq_err, irq_rxf, irq_txe, irq_tend}, 8'h00);
    chk("R1", "vec_valid", {7'b0, vec_valid}, 8'h00);
    // R6 transmit-end alone
    en_tend = 1; tick();
    chk("R6", "tend only", {6'b0, vec}, 8'd3);
    // R10 transmit-empty beats transmit-end
    en_txe = 1; tick();
    chk("R10", "txe over tend", {6'b0, vec}, 8'd2);
    // R11 both transmit flags cleared together
    cpu_rd = 1; tick();
    cpu_clr = 6'b000011; tick();
    chk("R11", "status tx", {2'b0, status}, 8'h00);
    tick();
    chk("R11", "no tend irq", {7'b0, irq_tend}, 8'h00);
    chk("R11", "no valid", {7'b0, vec_valid}, 8'h00);
    // R3 clear without read ignored
    flag_set = 6'b000100; tick();
    cpu_clr = 6'b000100; tick();
    chk("R3", "unarmed clear", {7'b0, status[2]}, 8'h01);
    cpu_rd = 1; tick();
    cpu_clr = 6'b000100; tick();
    chk("R3", "armed clear", {7'b0, status[2]}, 8'h00);
    // R4 set beats clear
    flag_set = 6'b000100; tick();
    cpu_rd = 1; tick();
    flag_set = 6'b000100; cpu_clr = 6'b000100; tick();
    chk("R4", "set over clear", {7'b0, status[2]}, 8'h01);
    // R8 DMA clears
    en_rxf = 1; dma_rx_ack = 1; tick();
    chk("R8", "dma rx clear", {7'b0, status[2]}, 8'h00);
    flag_set = 6'b000001; tick();
    dma_tx_ack = 1; tick();
    chk("R8", "dma tx clear", {7'b0, status[0]}, 8'h00);
    // R9 second engine conditions
    flag_set = 6'b000001; tick();
    xfer_hold = 1; xfer_tx_ack = 1; tick();
    chk("R9", "hold blocks", {7'b0, status[0]}, 8'h01);
    xfer_hold = 0; xfer_cnt_zero = 1; xfer_tx_ack = 1; tick();
    chk("R9", "zero count blocks", {7'b0, status[0]}, 8'h01);
    xfer_cnt_zero = 0; xfer_tx_ack = 1; tick();
    chk("R9", "xfer clears", {7'b0, status[0]}, 8'h00);
    // R7 / R10 error outranks receive-full
    en_err = 1; flag_set = 6'b010100; tick();
    chk("R7", "err irq", {7'b0, irq_err}, 8'h01);
    chk("R10", "err first", {6'b0, vec}, 8'd0);
    // random traffic, compared every cycle by the model
    for (int k = 0; k < 4000; k++) begin
      flag_set = ($urandom_range(0, 3) == 0) ? 6'($urandom) & 6'($urandom) : '0;
      cpu_rd = ($urandom_range(0, 3) == 0);
      cpu_clr = ($urandom_range(0, 2) == 0) ? 6'($urandom) : '0;
      dma_tx_ack = ($urandom_range(0, 7) == 0);
      dma_rx_ack = ($urandom_range(0, 7) == 0);
      xfer_tx_ack = ($urandom_range(0, 5) == 0);
      xfer_rx_ack = ($urandom_range(0, 5) == 0);
      xfer_hold = $urandom_range(0, 1) == 1;
      xfer_cnt_zero = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 15) == 0) {en_txe, en_tend, en_rxf, en_err} = 4'($urandom);
      tick();
    end
    finish_run();
  end
endmodule